// File: doc/BRIEF.md
# Debounced key matrix scanner

This block scans a matrix of six drive lines by five sense lines, up to thirty keys. While no key is held, the drive lines sit at their idle levels. A sense line going high starts a scan. The scan raises one drive line at a time and records which sense lines answer. Two complete scans run back to back. The result is accepted only when both agree. After an agreeing, non-empty result the block waits until a fixed delay from scan start has passed. It then latches the key bits into a status word and raises a request to the host. The host reads the word and pulses a done strobe. That clears the request and starts a new scan. The cycle repeats until a scan finds the matrix empty, and that clears the key bits.

A two-bit selection can give the first one or two drive lines to other use, which leaves 25 or 20 keys. A two-bit sleep code holds the idle drive lines at fixed patterns. A wake output tells the clock source to run whenever a scan is in progress or the block is awake. Mode inputs are taken only while the scanner is idle.

Top module: `keyscan_top`

## Requirements
- R1: After reset the status word is all zero, the request is low, all six drive lines are high and the wake output is high.
- R2: A scan drives exactly one drive line high at a time, in order from line 1 to line 6. Each line is held for 64 clocks. The scan starts on the third rising edge after a sense input goes high: two synchronizer flops, then the state register.
- R3: The request rises on the 800th rising edge after the edge that starts the scan.
- R4: The key on drive line d (1..6) and sense line s (1..5) is reported in status bit (d-1)*5+(s-1), with key_req high. Several keys held together are all reported.
- R5: The two back-to-back scans must agree. A press released before the second scan samples its line is never reported. If the scans differ while a key is still held, a fresh pair of scans is run.
- R6: Key select 0 uses all six lines. Key select 1 holds drive line 1 low and ignores its keys. Key select 2 or 3 holds drive lines 1 and 2 low and ignores their keys.
- R7: Sleep code 0 is normal, with all enabled lines high at idle. Code 1 drives all lines low, code 2 drives only line 6 high, and code 3 drives all lines except line 1 high. When the code is non-zero, status bit 30 is 1 and the wake output is low while idle. A key on a high line wakes the block, and it scans and requests as usual.
- R8: A read-done strobe while the request is high drops the request on the next edge and starts a new scan. A key still held raises the request again. A released matrix clears the key bits. Sleep stays set throughout.
- R9: Key select and sleep code changes take effect only while the scanner is idle, never during a scan, a wait or a pending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_sel | input | 2 | Number of drive lines given to keys (0: six, 1: five, 2/3: four) |
| sleep_code | input | 2 | Idle drive pattern; non-zero means sleep |
| read_done | input | 1 | One-clock strobe: host has read the status word |
| sense_in | input | 5 | Matrix sense lines, high when a key meets a high drive line |
| drive_out | output | 6 | Matrix drive lines, bit 0 is line 1 |
| key_req | output | 1 | High while accepted key data waits to be read |
| osc_run | output | 1 | Clock source must run |
| status | output | 31 | Bits 29:0 key bits, bit 30 sleep acknowledge |

## Verification
Every one of the thirty keys is pressed alone, so a wrong line order or bit mapping shows as a single misplaced bit. Keys sharing a sense line, and keys at opposite corners, show that rows are stored separately. One precise press checks the drive sequence and the exact request edge. A short press that ends between the two scans checks that it yields nothing. A press that moves to another key between the scans checks that only a repeated, agreeing scan is reported. The key-select and sleep sweeps press keys on enabled and disabled lines and compare idle drive patterns. A mode change made while a request is pending is checked for deferral.

// File: rtl/keyscan_pkg.sv
// Package: shared state encoding of the key scanner.
// Assumes: nothing beyond IEEE 1800-2017.
package keyscan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_CMP,
        ST_WAIT,
        ST_REQ
    } scan_state_t;

    localparam logic [1:0] SLP_NONE   = 2'd0;
    localparam logic [1:0] SLP_ALLLOW = 2'd1;
    localparam logic [1:0] SLP_TOPHI  = 2'd2;
    localparam logic [1:0] SLP_FIRSTL = 2'd3;

endpackage

// File: rtl/keyscan_sync.sv
// Module: two-flop synchronizer for the sense lines.
// Assumes: inputs are asynchronous levels; reset value is zero.
module keyscan_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Capture the asynchronous levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign q_out = stage2_q;
endmodule

// File: rtl/keyscan_drive.sv
// Module: drive-line level generator.
// Works out which lines belong to the matrix from the key select.
// Produces either the one-hot scan pattern or the idle pattern set by the sleep code.
// Assumes: N_DRIVE >= 2; mode inputs are already held stable by the caller.
module keyscan_drive
    import keyscan_pkg::*;
#(
    parameter int N_DRIVE = 6,
    localparam int STEP_W = (N_DRIVE > 1) ? $clog2(N_DRIVE) : 1
) (
    input  logic [1:0]         key_sel,
    input  logic [1:0]         sleep_code,
    input  logic               scanning,
    input  logic [STEP_W-1:0]  step_idx,
    output logic [N_DRIVE-1:0] line_en,
    output logic [N_DRIVE-1:0] drive
);
    logic [N_DRIVE-1:0] idle_pat;
    logic [N_DRIVE-1:0] scan_pat;

    // Per-line enable and scan selection, one slice per drive line.
    for (genvar i = 0; i < N_DRIVE; i++) begin : g_line
        if (i == 0) begin : g_first
            assign line_en[i] = (key_sel == 2'd0);
        end else if (i == 1) begin : g_second
            assign line_en[i] = !key_sel[1];
        end else begin : g_rest
            assign line_en[i] = 1'b1;
        end
        assign scan_pat[i] = line_en[i] && (step_idx == STEP_W'(i));
    end

    // Idle level pattern chosen by the sleep code, masked by the enables.
    always_comb begin
        case (sleep_code)
            SLP_NONE:   idle_pat = line_en;
            SLP_ALLLOW: idle_pat = '0;
            SLP_TOPHI:  idle_pat = line_en & (N_DRIVE'(1) << (N_DRIVE - 1));
            default:    idle_pat = line_en & ~N_DRIVE'(1);
        endcase
    end

    assign drive = scanning ? scan_pat : idle_pat;
endmodule

// File: rtl/keyscan_ctrl.sv
// Module: scan sequencer, double-scan comparison and request logic.
// Runs two scans of N_DRIVE steps of STEP_CLKS clocks each. It samples the
// synchronized sense lines in the last clock of every step and compares the
// two results. An agreeing, non-empty result is latched REQ_DELAY clocks after
// scan start and raises the request.
// Assumes: REQ_DELAY > 2*N_DRIVE*STEP_CLKS + 1; sense_s is already synchronized.
module keyscan_ctrl
    import keyscan_pkg::*;
#(
    parameter int N_DRIVE   = 6,
    parameter int N_SENSE   = 5,
    parameter int STEP_CLKS = 64,
    parameter int REQ_DELAY = 800,
    localparam int N_KEYS = N_DRIVE * N_SENSE,
    localparam int STEP_W = (N_DRIVE > 1) ? $clog2(N_DRIVE) : 1,
    localparam int CYC_W  = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1,
    localparam int T_W    = $clog2(REQ_DELAY + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SENSE-1:0] sense_s,
    input  logic               read_done,
    input  logic [N_DRIVE-1:0] line_en,
    output logic               scanning,
    output logic [STEP_W-1:0]  step_idx,
    output logic               idle,
    output logic               key_req,
    output logic [N_KEYS-1:0]  keys
);
    scan_state_t        state_q;
    logic [CYC_W-1:0]   cyc_q;
    logic [STEP_W-1:0]  step_q;
    logic               pass_q;
    logic [T_W-1:0]     tcnt_q;
    logic [N_KEYS-1:0]  buf_a_q;
    logic [N_KEYS-1:0]  buf_b_q;
    logic [N_KEYS-1:0]  keys_q;
    logic               req_q;
    logic [N_SENSE-1:0] row_val;

    // Row sample: a disabled drive line always reads as no key.
    assign row_val = line_en[step_q] ? sense_s : '0;

    // Sequencer: idle wait, two scans, comparison, delay, pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
            step_q  <= '0;
            pass_q  <= 1'b0;
            tcnt_q  <= '0;
            buf_a_q <= '0;
            buf_b_q <= '0;
            keys_q  <= '0;
            req_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (|sense_s) begin
                        state_q <= ST_SCAN;
                        cyc_q   <= '0;
                        step_q  <= '0;
                        pass_q  <= 1'b0;
                        tcnt_q  <= '0;
                    end
                end
                ST_SCAN: begin
                    tcnt_q <= tcnt_q + 1'b1;
                    if (cyc_q == CYC_W'(STEP_CLKS - 1)) begin
                        cyc_q <= '0;
                        if (pass_q) begin
                            buf_b_q[step_q*N_SENSE +: N_SENSE] <= row_val;
                        end else begin
                            buf_a_q[step_q*N_SENSE +: N_SENSE] <= row_val;
                        end
                        if (step_q == STEP_W'(N_DRIVE - 1)) begin
                            step_q <= '0;
                            if (pass_q) begin
                                state_q <= ST_CMP;
                            end else begin
                                pass_q <= 1'b1;
                            end
                        end else begin
                            step_q <= step_q + 1'b1;
                        end
                    end else begin
                        cyc_q <= cyc_q + 1'b1;
                    end
                end
                ST_CMP: begin
                    tcnt_q <= tcnt_q + 1'b1;
                    if ((buf_a_q == buf_b_q) && (|buf_b_q)) begin
                        state_q <= ST_WAIT;
                    end else if (|buf_b_q) begin
                        state_q <= ST_SCAN;
                        cyc_q   <= '0;
                        step_q  <= '0;
                        pass_q  <= 1'b0;
                        tcnt_q  <= '0;
                    end else begin
                        state_q <= ST_IDLE;
                        keys_q  <= '0;
                    end
                end
                ST_WAIT: begin
                    tcnt_q <= tcnt_q + 1'b1;
                    if (tcnt_q == T_W'(REQ_DELAY - 1)) begin
                        state_q <= ST_REQ;
                        keys_q  <= buf_b_q;
                        req_q   <= 1'b1;
                    end
                end
                ST_REQ: begin
                    if (read_done) begin
                        req_q   <= 1'b0;
                        state_q <= ST_SCAN;
                        cyc_q   <= '0;
                        step_q  <= '0;
                        pass_q  <= 1'b0;
                        tcnt_q  <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign scanning = (state_q == ST_SCAN);
    assign step_idx = step_q;
    assign idle     = (state_q == ST_IDLE);
    assign key_req  = req_q;
    assign keys     = keys_q;

    // R8
    req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && read_done) |=> !req_q);

    // R4
    req_keys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> (keys_q != '0));

    // R5
    keys_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(keys_q) |-> ($rose(req_q) || (keys_q == '0)));
endmodule

// File: rtl/keyscan_top.sv
// Module: debounced key matrix scanner, top level.
// Holds the mode registers, which load only while idle. Wires the sense
// synchronizer, the sequencer and the drive generator together, and forms
// the status word and the wake output.
// Assumes: one clock domain; sense lines are high when a pressed key meets a high drive line.
module keyscan_top #(
    parameter int N_DRIVE   = 6,
    parameter int N_SENSE   = 5,
    parameter int STEP_CLKS = 64,
    parameter int REQ_DELAY = 800,
    localparam int N_KEYS = N_DRIVE * N_SENSE,
    localparam int STEP_W = (N_DRIVE > 1) ? $clog2(N_DRIVE) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         key_sel,
    input  logic [1:0]         sleep_code,
    input  logic               read_done,
    input  logic [N_SENSE-1:0] sense_in,
    output logic [N_DRIVE-1:0] drive_out,
    output logic               key_req,
    output logic               osc_run,
    output logic [N_KEYS:0]    status
);
    logic [1:0]         ksel_q;
    logic [1:0]         sleep_q;
    logic [N_SENSE-1:0] sense_s;
    logic [N_DRIVE-1:0] line_en;
    logic               scanning;
    logic [STEP_W-1:0]  step_idx;
    logic               idle;
    logic [N_KEYS-1:0]  keys;

    // Mode registers: follow the inputs only while the scanner is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ksel_q  <= 2'd0;
            sleep_q <= 2'd0;
        end else if (idle) begin
            ksel_q  <= key_sel;
            sleep_q <= sleep_code;
        end
    end

    keyscan_sync #(.W(N_SENSE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (sense_in),
        .q_out (sense_s)
    );

    keyscan_ctrl #(
        .N_DRIVE   (N_DRIVE),
        .N_SENSE   (N_SENSE),
        .STEP_CLKS (STEP_CLKS),
        .REQ_DELAY (REQ_DELAY)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sense_s   (sense_s),
        .read_done (read_done),
        .line_en   (line_en),
        .scanning  (scanning),
        .step_idx  (step_idx),
        .idle      (idle),
        .key_req   (key_req),
        .keys      (keys)
    );

    keyscan_drive #(.N_DRIVE(N_DRIVE)) u_drive (
        .key_sel    (ksel_q),
        .sleep_code (sleep_q),
        .scanning   (scanning),
        .step_idx   (step_idx),
        .line_en    (line_en),
        .drive      (drive_out)
    );

    assign status  = {(sleep_q != 2'd0), keys};
    assign osc_run = (sleep_q == 2'd0) || !idle;

    // R2
    scan_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> $onehot0(drive_out));

    // R6
    seg_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ksel_q != 2'd0) |-> !drive_out[0]);

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> ($stable(ksel_q) && $stable(sleep_q)));
endmodule

// File: tb/keyscan_top_tb.sv
module keyscan_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  key_sel = 2'd0;
    logic [1:0]  sleep_code = 2'd0;
    logic        read_done = 1'b0;
    logic [4:0]  sense_in;
    logic [5:0]  drive_out;
    logic        key_req;
    logic        osc_run;
    logic [30:0] status;
    logic [29:0] pressed = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    keyscan_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_sel    (key_sel),
        .sleep_code (sleep_code),
        .read_done  (read_done),
        .sense_in   (sense_in),
        .drive_out  (drive_out),
        .key_req    (key_req),
        .osc_run    (osc_run),
        .status     (status)
    );

    // Matrix model: a pressed key connects its drive line to its sense line.
    always_comb begin
        sense_in = '0;
        for (int d = 0; d < 6; d++)
            for (int s = 0; s < 5; s++)
                if (drive_out[d] && pressed[d*5+s]) sense_in[s] = 1'b1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_req(input int n, output bit got);
        got = 0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (key_req) begin
                got = 1;
                break;
            end
        end
    endtask

    task automatic strobe_read();
        read_done = 1'b1;
        tick(1);
        read_done = 1'b0;
    endtask

    task automatic release_and_clear(input string tag);
        bit cleared;
        pressed = '0;
        strobe_read();
        cleared = 0;
        for (int i = 0; i < 1200; i++) begin
            tick(1);
            if (status[29:0] == '0) begin
                cleared = 1;
                break;
            end
        end
        check(tag, {31'd0, cleared}, 32'd1);
        tick(3);
    endtask

    task automatic press_cycle(input logic [29:0] mask, input logic [29:0] exp, input string tag);
        bit got;
        pressed = mask;
        wait_req(1200, got);
        check(tag, {31'd0, got}, 32'd1);
        check(tag, {2'd0, status[29:0]}, {2'd0, exp});
        release_and_clear(tag);
    endtask

    task automatic press_none(input logic [29:0] mask, input string tag);
        bit got;
        pressed = mask;
        wait_req(1200, got);
        check(tag, {31'd0, got}, 32'd0);
        pressed = '0;
        tick(5);
    endtask

    initial begin
        #750000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit got;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 status", {1'b0, status}, 32'd0);
        check("R1 req", {31'd0, key_req}, 32'd0);
        check("R1 drive", {26'd0, drive_out}, 32'h3F);
        check("R1 osc", {31'd0, osc_run}, 32'd1);

        // R2 / R3 scan sequence and request edge, key K1
        pressed = 30'd1;
        for (int k = 1; k <= 803; k++) begin
            tick(1);
            if (k == 3)   check("R2 step1", {26'd0, drive_out}, 32'h01);
            if (k == 67)  check("R2 step2", {26'd0, drive_out}, 32'h02);
            if (k == 131) check("R2 step3", {26'd0, drive_out}, 32'h04);
            if (k == 802) check("R3 early", {31'd0, key_req}, 32'd0);
            if (k == 803) check("R3 edge", {31'd0, key_req}, 32'd1);
        end
        check("R4 K1", {2'd0, status[29:0]}, 32'd1);
        // R8 read clears, held key re-requests
        strobe_read();
        check("R8 clear", {31'd0, key_req}, 32'd0);
        wait_req(1200, got);
        check("R8 repeat", {31'd0, got}, 32'd1);
        check("R8 repeat data", {2'd0, status[29:0]}, 32'd1);
        release_and_clear("R8 release");
        check("R8 idle req", {31'd0, key_req}, 32'd0);

        // R4 every single key
        for (int k = 0; k < 30; k++)
            press_cycle(30'd1 << k, 30'd1 << k, $sformatf("R4 K%0d", k + 1));
        // R4 multiple keys
        press_cycle((30'd1 << 0) | (30'd1 << 29), (30'd1 << 0) | (30'd1 << 29), "R4 corners");
        press_cycle(30'h00000421, 30'h00000421, "R4 column");

        // R5 short press released between scans
        pressed = 30'd1;
        tick(300);
        pressed = '0;
        wait_req(1500, got);
        check("R5 short", {31'd0, got}, 32'd0);
        check("R5 short data", {2'd0, status[29:0]}, 32'd0);
        // R5 moved press forces rescan
        pressed = 30'd1;
        tick(300);
        pressed = 30'd1 << 6;
        wait_req(2500, got);
        check("R5 rescan", {31'd0, got}, 32'd1);
        check("R5 rescan data", {2'd0, status[29:0]}, 32'h40);
        release_and_clear("R5 rescan release");

        // R6 key select
        key_sel = 2'd1;
        tick(2);
        check("R6 sel1 drive", {26'd0, drive_out}, 32'h3E);
        press_none(30'd1, "R6 sel1 K1");
        press_cycle(30'd1 << 5, 30'd1 << 5, "R6 sel1 K6");
        key_sel = 2'd2;
        tick(2);
        check("R6 sel2 drive", {26'd0, drive_out}, 32'h3C);
        press_none(30'd1 << 5, "R6 sel2 K6");
        press_cycle(30'd1 << 10, 30'd1 << 10, "R6 sel2 K11");
        key_sel = 2'd3;
        tick(2);
        check("R6 sel3 drive", {26'd0, drive_out}, 32'h3C);
        key_sel = 2'd0;
        tick(2);

        // R9 mode change deferred while a request is pending
        pressed = 30'd1 << 1;
        wait_req(1200, got);
        check("R9 req", {31'd0, got}, 32'd1);
        key_sel = 2'd1;
        tick(5);
        check("R9 held drive", {26'd0, drive_out}, 32'h3F);
        release_and_clear("R9 release");
        check("R9 applied drive", {26'd0, drive_out}, 32'h3E);
        key_sel = 2'd0;
        tick(2);

        // R7 sleep codes
        sleep_code = 2'd2;
        tick(2);
        check("R7 code2 drive", {26'd0, drive_out}, 32'h20);
        check("R7 ack", {31'd0, status[30]}, 32'd1);
        check("R7 osc off", {31'd0, osc_run}, 32'd0);
        press_none(30'd1, "R7 low line K1");
        check("R7 osc still off", {31'd0, osc_run}, 32'd0);
        pressed = 30'd1 << 25;
        wait_req(1200, got);
        check("R7 wake", {31'd0, got}, 32'd1);
        check("R7 wake data", {1'b0, status}, {1'b0, 1'b1, 30'd1 << 25});
        check("R7 osc on", {31'd0, osc_run}, 32'd1);
        release_and_clear("R7 wake release");
        check("R8 sleep kept", {31'd0, status[30]}, 32'd1);
        check("R7 osc off again", {31'd0, osc_run}, 32'd0);
        sleep_code = 2'd3;
        tick(2);
        check("R7 code3 drive", {26'd0, drive_out}, 32'h3E);
        sleep_code = 2'd1;
        tick(2);
        check("R7 code1 drive", {26'd0, drive_out}, 32'h00);
        sleep_code = 2'd0;
        tick(2);
        check("R7 normal drive", {26'd0, drive_out}, 32'h3F);
        check("R7 ack off", {31'd0, status[30]}, 32'd0);
        check("R7 osc normal", {31'd0, osc_run}, 32'd1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule